// File: doc/BRIEF.md
# Increment-and-skip instruction unit

This unit executes two byte-oriented instructions of a small 8-bit accumulator machine. Each adds one to an 8-bit file register and then tells the fetch stage whether to throw away the instruction it has already prefetched. The opcode sets the skip sense. One opcode skips when the incremented value is zero, and the other skips when it is nonzero. The instruction word carries a destination bit, a bank-mode bit and an 8-bit file address.

The unit resolves the file address into a 12-bit register-file address. It does this through a fixed access window or through a 4-bit bank register. It reads the operand from a combinational read port in the cycle the instruction is presented. One clock later it drives either a register-file write or a working-register write, and the skip outputs in that same cycle. The fetch stage says whether the following instruction takes two words. This decides whether a skip squashes one word or two.

Top module: `incsk_unit`

## Requirements
- R1: Only two instruction words are recognised. Bits [15:10] = 6'b001111 is skip-on-zero and 6'b010010 is skip-on-nonzero. Bit 9 is the destination bit, bit 8 is the bank-mode bit and bits [7:0] are the file address f.
- R2: In the cycle a recognised instruction is valid, `rf_raddr` is driven with the resolved address. With bank-mode 0 it is {4'h0,f} for f < 8'h60 and {4'hF,f} for f >= 8'h60. With bank-mode 1 it is {bank_sel,f}.
- R3: The result is `rf_rdata` + 1 modulo 256, so 8'hFF gives 8'h00.
- R4: The destination bit selects the target. With 0, `w_we` is high with `w_wdata` = result and `rf_we` is low. With 1, `rf_we` is high with `rf_waddr` = the resolved address and `rf_wdata` = result, and `w_we` is low.
- R5: `skip_pulse` is high when the wrapped result is zero for the skip-on-zero opcode, or nonzero for the skip-on-nonzero opcode, and low otherwise.
- R6: `squash_cnt` is 2 when a skip is taken and `next_two_word` was high with the instruction. It is 1 for a skip otherwise, and 0 when no skip is taken.
- R7: All write strobes and skip outputs appear exactly one clock after the instruction cycle and last one cycle.
- R8: A word that is not recognised, or any word while `instr_valid` is low, causes no write, no skip and a squash count of 0.
- R9: While reset is held and in the first cycle after it, `rf_we`, `w_we` and `skip_pulse` are low and `squash_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 16 | Instruction word |
| bank_sel | input | 4 | Bank register, upper address bits in bank mode |
| next_two_word | input | 1 | Fetch stage: the prefetched instruction takes two words |
| rf_raddr | output | 12 | Register-file read address |
| rf_rdata | input | 8 | Register-file read data, combinational |
| rf_we | output | 1 | Register-file write strobe |
| rf_waddr | output | 12 | Register-file write address |
| rf_wdata | output | 8 | Register-file write data |
| w_we | output | 1 | Working-register write strobe |
| w_wdata | output | 8 | Working-register write data |
| skip_pulse | output | 1 | Skip taken, one cycle |
| squash_cnt | output | 2 | Number of prefetched words to discard |

## Verification
The two-word squash is the hardest case to reach. It needs a skip and a high `next_two_word` together, and with random operands the skip-on-zero opcode fires only about once in 256. The stimulus forces the operand to 8'hFF in a share of the random instructions and drives `next_two_word` at random. This covers every mix of opcode, wrap and two-word flag. Directed cases also cover the access-window boundary at 8'h5F and 8'h60, unrecognised words, and a valid opcode presented with `instr_valid` low.

// File: rtl/incsk_pkg.sv
package incsk_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {OP_NONE = 2'd0, OP_SKZ = 2'd1, OP_SKNZ = 2'd2} op_e;

  typedef struct packed {
    op_e        op;
    logic       to_file;
    logic       use_bank;
    logic [7:0] faddr;
  } dec_t;

  localparam logic [5:0] SKZ_CODE  = 6'b001111;
  localparam logic [5:0] SKNZ_CODE = 6'b010010;

  function automatic dec_t decode_word(input logic valid, input logic [WORD_W-1:0] w);
    dec_t d;
    d.to_file  = w[9];
    d.use_bank = w[8];
    d.faddr    = w[7:0];
    if (!valid)                  d.op = OP_NONE;
    else if (w[15:10] == SKZ_CODE)  d.op = OP_SKZ;
    else if (w[15:10] == SKNZ_CODE) d.op = OP_SKNZ;
    else                         d.op = OP_NONE;
    return d;
  endfunction

  function automatic logic [7:0] bump(input logic [7:0] v);
    return v + 8'd1;
  endfunction

  function automatic logic skip_rule(input op_e op, input logic [7:0] res);
    case (op)
      OP_SKZ:  return (res == 8'd0);
      OP_SKNZ: return (res != 8'd0);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [1:0] squash_words(input logic skip, input logic two);
    if (!skip) return 2'd0;
    return two ? 2'd2 : 2'd1;
  endfunction
endpackage

// File: rtl/incsk_decode.sv
module incsk_decode
  import incsk_pkg::*;
(
  input  logic              valid,
  input  logic [WORD_W-1:0] word,
  output dec_t              dec
);
  always_comb dec = decode_word(valid, word);
endmodule

// File: rtl/incsk_bank_map.sv
module incsk_bank_map #(
  parameter int FADDR_W = 8,
  parameter int BANK_W  = 4,
  parameter logic [FADDR_W-1:0] SPLIT = 8'h60,
  localparam int ADDR_W = FADDR_W + BANK_W
) (
  input  logic               use_bank,
  input  logic [FADDR_W-1:0] faddr,
  input  logic [BANK_W-1:0]  bank_sel,
  output logic [ADDR_W-1:0]  addr
);
  always_comb begin
    if (use_bank)            addr = {bank_sel, faddr};
    else if (faddr < SPLIT)  addr = {{BANK_W{1'b0}}, faddr};
    else                     addr = {{BANK_W{1'b1}}, faddr};
  end
endmodule

// File: rtl/incsk_skip_ctl.sv
module incsk_skip_ctl
  import incsk_pkg::*;
(
  input  op_e        op,
  input  logic [7:0] result,
  input  logic       two_word,
  output logic       skip,
  output logic [1:0] squash
);
  always_comb begin
    skip   = skip_rule(op, result);
    squash = squash_words(skip, two_word);
  end
endmodule

// File: rtl/incsk_unit.sv
module incsk_unit
  import incsk_pkg::*;
#(
  parameter int FADDR_W = 8,
  parameter int BANK_W  = 4,
  parameter int DATA_W  = 8,
  localparam int ADDR_W = FADDR_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [15:0]       instr_word,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              next_two_word,
  output logic [ADDR_W-1:0] rf_raddr,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              rf_we,
  output logic [ADDR_W-1:0] rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              w_we,
  output logic [DATA_W-1:0] w_wdata,
  output logic              skip_pulse,
  output logic [1:0]        squash_cnt
);
  dec_t              dec;
  logic              op_hit;
  logic [ADDR_W-1:0] eff_addr;
  logic [7:0]        sum;
  logic              skip_now;
  logic [1:0]        squash_now;

  incsk_decode u_dec (.valid(instr_valid), .word(instr_word), .dec(dec));

  incsk_bank_map #(.FADDR_W(FADDR_W), .BANK_W(BANK_W)) u_map (
    .use_bank(dec.use_bank), .faddr(dec.faddr[FADDR_W-1:0]),
    .bank_sel(bank_sel), .addr(eff_addr));

  assign op_hit   = (dec.op != OP_NONE);
  assign rf_raddr = eff_addr;
  assign sum      = bump(rf_rdata[7:0]);

  incsk_skip_ctl u_skip (.op(dec.op), .result(sum), .two_word(next_two_word),
    .skip(skip_now), .squash(squash_now));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rf_we      <= 1'b0;
      w_we       <= 1'b0;
      skip_pulse <= 1'b0;
      squash_cnt <= 2'd0;
      rf_waddr   <= '0;
      rf_wdata   <= '0;
      w_wdata    <= '0;
    end else begin
      rf_we      <= op_hit && dec.to_file;
      w_we       <= op_hit && !dec.to_file;
      skip_pulse <= op_hit && skip_now;
      squash_cnt <= op_hit ? squash_now : 2'd0;
      if (op_hit) begin
        rf_waddr <= eff_addr;
        rf_wdata <= sum;
        w_wdata  <= sum;
      end
    end
  end
endmodule

// File: rtl/incsk_unit_chk.sv
module incsk_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_hit,
  input logic        use_bank,
  input logic [11:0] rf_raddr,
  input logic [7:0]  rf_rdata,
  input logic        rf_we,
  input logic [7:0]  rf_wdata,
  input logic        w_we,
  input logic [7:0]  w_wdata,
  input logic        skip_pulse,
  input logic [1:0]  squash_cnt
);
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we && w_we)); // R4
  AST_FILE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> rf_wdata == $past(rf_rdata) + 8'd1); // R3
  AST_W_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    w_we |-> w_wdata == $past(rf_rdata) + 8'd1); // R3
  AST_SQUASH_WITH_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    skip_pulse |-> squash_cnt != 2'd0); // R6
  AST_NO_SQUASH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !skip_pulse |-> squash_cnt == 2'd0); // R6
  AST_STROBE_FOLLOWS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we || w_we) |-> $past(op_hit)); // R7
  AST_OP_MAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    op_hit |=> (rf_we || w_we)); // R8
  AST_ACCESS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (op_hit && !use_bank) |-> (rf_raddr[11:8] == 4'h0 || rf_raddr[11:8] == 4'hF)); // R2
endmodule

bind incsk_unit incsk_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_hit(op_hit), .use_bank(dec.use_bank),
  .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_wdata(rf_wdata),
  .w_we(w_we), .w_wdata(w_wdata), .skip_pulse(skip_pulse), .squash_cnt(squash_cnt));

// File: tb/incsk_unit_test.sv
module incsk_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [15:0] instr_word = 16'h0;
  logic [3:0]  bank_sel = 4'h0;
  logic        next_two_word = 1'b0;
  logic [11:0] rf_raddr;
  logic [7:0]  rf_rdata = 8'h0;
  logic        rf_we;
  logic [11:0] rf_waddr;
  logic [7:0]  rf_wdata;
  logic        w_we;
  logic [7:0]  w_wdata;
  logic        skip_pulse;
  logic [1:0]  squash_cnt;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  incsk_unit uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit known(input logic [15:0] w);
    return (w[15:10] == 6'b001111) || (w[15:10] == 6'b010010);
  endfunction

  function automatic logic [11:0] ref_addr(input logic [15:0] w, input logic [3:0] b);
    logic [7:0] f = w[7:0];
    if (w[8]) return {b, f};
    return (f >= 8'h60) ? {4'hF, f} : {4'h0, f};
  endfunction

  function automatic bit ref_skip(input logic [15:0] w, input logic [7:0] opnd);
    logic [8:0] s = {1'b0, opnd} + 9'd1;
    bit zero = (s[7:0] == 8'd0);
    return (w[15:10] == 6'b001111) ? zero : !zero;
  endfunction

  task automatic run_op(input bit v, input logic [15:0] w, input logic [3:0] b,
                        input bit two, input logic [7:0] opnd);
    bit hit = v && known(w);
    logic [7:0] res = opnd + 8'd1;
    bit sk;
    logic [11:0] ea = ref_addr(w, b);
    sk = hit && ref_skip(w, opnd);
    @(negedge clk);
    instr_valid = v; instr_word = w; bank_sel = b; next_two_word = two; rf_rdata = opnd;
    #1;
    if (hit) chk(rf_raddr == ea, "R2 read address", rf_raddr, ea);
    @(posedge clk);
    @(negedge clk);
    instr_valid = 1'b0;
    if (!hit) begin
      chk(!rf_we && !w_we, "R8 no write", {rf_we, w_we}, 0);
      chk(!skip_pulse && squash_cnt == 0, "R8 no skip", {skip_pulse, squash_cnt}, 0);
    end else begin
      if (w[9]) begin
        chk(rf_we && !w_we, "R4 file dest strobes", {rf_we, w_we}, 2);
        chk(rf_waddr == ea, "R4 write address", rf_waddr, ea);
        chk(rf_wdata == res, "R3 file result", rf_wdata, res);
      end else begin
        chk(w_we && !rf_we, "R4 W dest strobes", {rf_we, w_we}, 1);
        chk(w_wdata == res, "R3 W result", w_wdata, res);
      end
      chk(skip_pulse == sk, "R5 skip", skip_pulse, sk);
      chk(squash_cnt == (sk ? (two ? 2 : 1) : 0), "R6 squash", squash_cnt,
          sk ? (two ? 2 : 1) : 0);
    end
    @(negedge clk);
    chk(!rf_we && !w_we && !skip_pulse, "R7 one-cycle strobes",
        {rf_we, w_we, skip_pulse}, 0);
  endtask

  initial begin
    #400000;
    nerr++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!rf_we && !w_we && !skip_pulse && squash_cnt == 0, "R9 reset state",
        {rf_we, w_we, skip_pulse, squash_cnt}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rf_we && !w_we && !skip_pulse && squash_cnt == 0, "R9 after reset",
        {rf_we, w_we, skip_pulse, squash_cnt}, 0);
    // R1 R3 R5 R6 wrap cases for both opcodes
    run_op(1, 16'h3E10, 4'h2, 1'b0, 8'hFF);
    run_op(1, 16'h3E10, 4'h2, 1'b1, 8'hFF);
    run_op(1, 16'h4A10, 4'h2, 1'b1, 8'hFF);
    run_op(1, 16'h4A10, 4'h2, 1'b1, 8'h05);
    run_op(1, 16'h3C20, 4'h2, 1'b1, 8'h05);
    // R2 access window boundary and bank mode
    run_op(1, 16'h3E5F, 4'h7, 1'b0, 8'h11);
    run_op(1, 16'h3E60, 4'h7, 1'b0, 8'h11);
    run_op(1, 16'h4BFF, 4'h9, 1'b0, 8'h11);
    // R8 unrecognised words and valid low
    run_op(1, 16'h3A10, 4'h0, 1'b1, 8'hFF);
    run_op(1, 16'h4E10, 4'h0, 1'b1, 8'hFF);
    run_op(0, 16'h3E10, 4'h0, 1'b1, 8'hFF);
    for (int i = 0; i < 400; i++) begin
      logic [15:0] w;
      logic [7:0]  o;
      int sel = $urandom_range(0, 7);
      w = (sel < 4) ? {6'b001111, 10'($urandom)} :
          (sel < 7) ? {6'b010010, 10'($urandom)} : 16'($urandom);
      o = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom);
      run_op($urandom_range(0, 9) != 0, w, 4'($urandom), 1'($urandom), o);
    end
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule